// File: doc/BRIEF.md
# Rotating-Parity Stripe Mapper and XOR Engine

This block serves a disk array that stripes data one whole block at a time across `NUM_DISKS` drives. Each stripe holds one parity block and `NUM_DISKS-1` data blocks. The parity block moves to a different drive on each successive stripe, so parity traffic is spread over every drive. When a command is accepted, the block turns a logical block number into its stripe index, the drive that holds the data, and the drive that holds that stripe's parity. It then streams whole blocks in and returns the XOR result as one block.

Three operations share one XOR accumulator.

- A full-stripe write takes every data block of the stripe and produces the parity block.
- A small write takes exactly three blocks: the old data, the old parity and the new data. It returns the new parity, so the controller reads two blocks and writes two, and never reads the rest of the stripe.
- A rebuild takes the surviving blocks of a stripe and regenerates the block that belonged to a lost drive.

For every input block, the block reports which drive the controller should fetch it from. With the result, it reports which drive the result belongs on.

Words move one per cycle over valid/ready streams. Blocks are sent one after another, word 0 of each block first. A small write touches only its data drive and its parity drive. Two small writes whose drives do not overlap can therefore be issued by the controller on separate engines at the same time.

Top module: `stripe_parity_unit`

## Requirements
- R1: On an accepted command with `cmd_op` 0, 1 or 2, `cur_stripe` becomes `cmd_lba / (NUM_DISKS-1)`. `cur_parity_disk` becomes `(NUM_DISKS-1) - (cur_stripe mod NUM_DISKS)`. Both are visible from the cycle after acceptance.
- R2: `cur_data_disk` is chosen by taking the non-parity drives of the stripe in increasing order and indexing them with `cmd_lba mod (NUM_DISKS-1)`. It never equals `cur_parity_disk`.
- R3: A full-stripe write (`cmd_op`=0) absorbs `NUM_DISKS-1` blocks of `BLK_WORDS` words each. It then emits `BLK_WORDS` words, where word w is the XOR of word w of every absorbed block. `out_dst_disk` equals the parity drive.
- R4: During a full-stripe write, `in_src_disk` steps through the drives other than the parity drive in increasing order, one drive per block.
- R5: A small write (`cmd_op`=1) absorbs three blocks, with `in_src_disk` equal to the data drive, then the parity drive, then the data drive (old data, old parity, new data). It emits their word-wise XOR with `out_dst_disk` equal to the parity drive. This equals the parity of the stripe recomputed with the new data.
- R6: A rebuild (`cmd_op`=2) absorbs `NUM_DISKS-1` blocks from every drive except `cmd_lost_disk`, in increasing drive order. It emits their word-wise XOR with `out_dst_disk` equal to `cmd_lost_disk`.
- R7: At most one of `cmd_ready`, `in_ready` and `out_valid` is high in any cycle, in the order command, absorb, emit. While `out_valid` is high and `out_ready` is low, `out_data` and `out_dst_disk` hold their values.
- R8: `cmd_op`=3 is accepted and does nothing. No input is requested, no word is emitted, `cmd_ready` stays high, and the `cur_*` outputs keep their values.
- R9: After reset, `cmd_ready` is 1, `in_ready` and `out_valid` are 0, and the `cur_*` outputs are 0.
- R10: `out_last` is high only on the final (`BLK_WORDS`-th) word of the result. After that word is taken, `cmd_ready` is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken this cycle if valid |
| cmd_op | input | 2 | 0 full-stripe write, 1 small write, 2 rebuild, 3 no operation |
| cmd_lba | input | LBA_W | Logical block number (any block of the stripe for op 0 and 2) |
| cmd_lost_disk | input | DISK_W | Drive to regenerate (op 2) |
| cur_stripe | output | LBA_W | Stripe of the current command |
| cur_data_disk | output | DISK_W | Drive holding the addressed logical block |
| cur_parity_disk | output | DISK_W | Parity drive of the stripe |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Engine absorbing input words |
| in_data | input | WORD_W | Input word |
| in_src_disk | output | DISK_W | Drive the current input block comes from |
| out_valid | output | 1 | Result word offered |
| out_ready | input | 1 | Result word taken |
| out_data | output | WORD_W | Result word |
| out_last | output | 1 | Final word of the result block |
| out_dst_disk | output | DISK_W | Drive the result is written to |

## Verification
The bench moves the parity through every drive position over consecutive stripes. This exposes a mapper that rotates the wrong way, because its parity drive would disagree with the reference. It also exposes a data-drive numbering that fails to skip the parity drive, because the data block would land on the parity drive. Rebuilds are aimed at drive 0, at the top drive and at the parity drive, which catches a source walk that mishandles a skipped drive at either end: it would request a block from the lost drive or drop one.

A small write is checked against parity recomputed from the whole updated stripe. An engine that takes the wrong number of blocks, or asks for them in the wrong order, returns a wrong parity word. Output stalls, input bubbles and a no-operation command are also applied. An engine that advanced on a stalled output or started work on opcode 3 would send the per-cycle handshake model out of step.

// File: rtl/spu_pkg.sv
package spu_pkg;

    typedef enum logic [1:0] {
        OP_FULL    = 2'd0,
        OP_SMALL   = 2'd1,
        OP_REBUILD = 2'd2,
        OP_NONE    = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ABSORB = 2'd1,
        ST_EMIT   = 2'd2
    } st_e;

endpackage

// File: rtl/stripe_map.sv
module stripe_map #(
    parameter int NUM_DISKS = 5,
    parameter int LBA_W     = 16,
    localparam int DISK_W   = $clog2(NUM_DISKS)
) (
    input  logic [LBA_W-1:0]  lba,
    output logic [LBA_W-1:0]  stripe,
    output logic [DISK_W-1:0] data_disk,
    output logic [DISK_W-1:0] parity_disk
);
    localparam logic [LBA_W-1:0] DATA_PER_STRIPE = LBA_W'(NUM_DISKS - 1);
    localparam logic [LBA_W-1:0] DISK_COUNT      = LBA_W'(NUM_DISKS);

    logic [LBA_W-1:0] slot;
    logic [LBA_W-1:0] turn;
    logic [LBA_W-1:0] par_wide;
    logic [LBA_W-1:0] dat_wide;

    always_comb begin
        stripe   = lba / DATA_PER_STRIPE;
        slot     = lba % DATA_PER_STRIPE;
        turn     = stripe % DISK_COUNT;
        // parity moves down one drive per stripe, wrapping at the top
        par_wide = DATA_PER_STRIPE - turn;
        // data slots fill the non-parity drives in increasing order
        dat_wide = (slot < par_wide) ? slot : slot + LBA_W'(1);
        parity_disk = DISK_W'(par_wide);
        data_disk   = DISK_W'(dat_wide);
    end
endmodule

// File: rtl/disk_walk.sv
module disk_walk #(
    parameter int NUM_DISKS = 5,
    localparam int DISK_W   = $clog2(NUM_DISKS)
) (
    input  logic [DISK_W-1:0] cur,
    input  logic [DISK_W-1:0] skip,
    output logic [DISK_W-1:0] nxt
);
    logic [DISK_W-1:0] plus1;

    // cur of all ones wraps to 0, which yields the first drive of a walk
    always_comb begin
        plus1 = cur + DISK_W'(1);
        nxt   = (plus1 == skip) ? cur + DISK_W'(2) : plus1;
    end
endmodule

// File: rtl/block_xor_buf.sv
module block_xor_buf #(
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 4,
    localparam int IDX_W    = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] acc_d [BLK_WORDS];
    logic [WORD_W-1:0] acc_q [BLK_WORDS];

    for (genvar g = 0; g < BLK_WORDS; g++) begin : g_word
        always_comb begin
            if (clr) begin
                acc_d[g] = '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                acc_d[g] = acc_q[g] ^ wr_data;
            end else begin
                acc_d[g] = acc_q[g];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q[g] <= '0;
            end else begin
                acc_q[g] <= acc_d[g];
            end
        end
    end

    assign rd_data = acc_q[rd_idx];
endmodule

// File: rtl/stripe_parity_unit.sv
module stripe_parity_unit
    import spu_pkg::*;
#(
    parameter int NUM_DISKS = 5,
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 4,
    parameter int LBA_W     = 16,
    localparam int DISK_W   = $clog2(NUM_DISKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [LBA_W-1:0]  cmd_lba,
    input  logic [DISK_W-1:0] cmd_lost_disk,
    output logic [LBA_W-1:0]  cur_stripe,
    output logic [DISK_W-1:0] cur_data_disk,
    output logic [DISK_W-1:0] cur_parity_disk,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic [DISK_W-1:0] in_src_disk,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last,
    output logic [DISK_W-1:0] out_dst_disk
);
    localparam int IDX_W = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1;
    localparam logic [IDX_W-1:0]  LAST_WORD    = IDX_W'(BLK_WORDS - 1);
    localparam logic [DISK_W-1:0] LAST_STRIPE  = DISK_W'(NUM_DISKS - 2);
    localparam logic [DISK_W-1:0] LAST_SMALL   = DISK_W'(2);

    if (NUM_DISKS < 3) begin : g_bad_count
        $error("stripe_parity_unit needs at least three drives");
    end

    typedef struct packed {
        st_e               st;
        op_e               op;
        logic [IDX_W-1:0]  wcnt;
        logic [DISK_W-1:0] bcnt;
        logic [DISK_W-1:0] blast;
        logic [DISK_W-1:0] src;
        logic [DISK_W-1:0] dst;
        logic [DISK_W-1:0] dat;
        logic [DISK_W-1:0] par;
        logic [LBA_W-1:0]  stripe;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [LBA_W-1:0]  map_stripe;
    logic [DISK_W-1:0] map_data;
    logic [DISK_W-1:0] map_par;
    logic [DISK_W-1:0] first_skip;
    logic [DISK_W-1:0] first_src;
    logic [DISK_W-1:0] next_src;
    logic              acc_clr;
    logic              acc_wr;

    stripe_map #(.NUM_DISKS(NUM_DISKS), .LBA_W(LBA_W)) u_map (
        .lba         (cmd_lba),
        .stripe      (map_stripe),
        .data_disk   (map_data),
        .parity_disk (map_par)
    );

    assign first_skip = (cmd_op == OP_REBUILD) ? cmd_lost_disk : map_par;

    disk_walk #(.NUM_DISKS(NUM_DISKS)) u_first (
        .cur  ('1),
        .skip (first_skip),
        .nxt  (first_src)
    );

    disk_walk #(.NUM_DISKS(NUM_DISKS)) u_step (
        .cur  (ctl_q.src),
        .skip (ctl_q.dst),
        .nxt  (next_src)
    );

    block_xor_buf #(.WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (acc_clr),
        .wr_en   (acc_wr),
        .wr_idx  (ctl_q.wcnt),
        .wr_data (in_data),
        .rd_idx  (ctl_q.wcnt),
        .rd_data (out_data)
    );

    always_comb begin
        ctl_d   = ctl_q;
        acc_clr = 1'b0;
        acc_wr  = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (cmd_valid && (cmd_op != OP_NONE)) begin
                    ctl_d.st     = ST_ABSORB;
                    ctl_d.op     = op_e'(cmd_op);
                    ctl_d.wcnt   = '0;
                    ctl_d.bcnt   = '0;
                    ctl_d.stripe = map_stripe;
                    ctl_d.dat    = map_data;
                    ctl_d.par    = map_par;
                    acc_clr      = 1'b1;
                    case (op_e'(cmd_op))
                        OP_SMALL: begin
                            ctl_d.dst   = map_par;
                            ctl_d.src   = map_data;
                            ctl_d.blast = LAST_SMALL;
                        end
                        OP_REBUILD: begin
                            ctl_d.dst   = cmd_lost_disk;
                            ctl_d.src   = first_src;
                            ctl_d.blast = LAST_STRIPE;
                        end
                        default: begin
                            ctl_d.dst   = map_par;
                            ctl_d.src   = first_src;
                            ctl_d.blast = LAST_STRIPE;
                        end
                    endcase
                end
            end
            ST_ABSORB: begin
                if (in_valid) begin
                    acc_wr = 1'b1;
                    if (ctl_q.wcnt == LAST_WORD) begin
                        ctl_d.wcnt = '0;
                        if (ctl_q.bcnt == ctl_q.blast) begin
                            ctl_d.st   = ST_EMIT;
                            ctl_d.bcnt = '0;
                        end else begin
                            ctl_d.bcnt = ctl_q.bcnt + DISK_W'(1);
                            if (ctl_q.op == OP_SMALL) begin
                                // old data, old parity, new data
                                ctl_d.src = (ctl_q.bcnt == '0) ? ctl_q.par : ctl_q.dat;
                            end else begin
                                ctl_d.src = next_src;
                            end
                        end
                    end else begin
                        ctl_d.wcnt = ctl_q.wcnt + IDX_W'(1);
                    end
                end
            end
            ST_EMIT: begin
                if (out_ready) begin
                    if (ctl_q.wcnt == LAST_WORD) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.wcnt = '0;
                    end else begin
                        ctl_d.wcnt = ctl_q.wcnt + IDX_W'(1);
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= ctl_t'('0);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cmd_ready       = (ctl_q.st == ST_IDLE);
    assign in_ready        = (ctl_q.st == ST_ABSORB);
    assign out_valid       = (ctl_q.st == ST_EMIT);
    assign out_last        = (ctl_q.st == ST_EMIT) && (ctl_q.wcnt == LAST_WORD);
    assign in_src_disk     = ctl_q.src;
    assign out_dst_disk    = ctl_q.dst;
    assign cur_stripe      = ctl_q.stripe;
    assign cur_data_disk   = ctl_q.dat;
    assign cur_parity_disk = ctl_q.par;
endmodule

// File: rtl/spu_checker.sv
module spu_checker #(
    parameter int NUM_DISKS = 5,
    parameter int WORD_W    = 32,
    localparam int DISK_W   = $clog2(NUM_DISKS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [1:0]        cmd_op,
    input logic [DISK_W-1:0] cur_data_disk,
    input logic [DISK_W-1:0] cur_parity_disk,
    input logic              in_ready,
    input logic [DISK_W-1:0] in_src_disk,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic              out_last,
    input logic [DISK_W-1:0] out_dst_disk
);
    p_parity_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |-> (32'(cur_parity_disk) < NUM_DISKS));

    p_data_off_parity_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |-> (cur_data_disk != cur_parity_disk));

    p_src_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (32'(in_src_disk) < NUM_DISKS));

    p_one_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_ready, in_ready, out_valid}));

    p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_dst_disk)));

    p_nop_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && (cmd_op == 2'd3)) |=> (cmd_ready && !in_ready));

    p_last_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    p_back_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> cmd_ready);
endmodule

bind stripe_parity_unit spu_checker #(
    .NUM_DISKS (NUM_DISKS),
    .WORD_W    (WORD_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cmd_valid       (cmd_valid),
    .cmd_ready       (cmd_ready),
    .cmd_op          (cmd_op),
    .cur_data_disk   (cur_data_disk),
    .cur_parity_disk (cur_parity_disk),
    .in_ready        (in_ready),
    .in_src_disk     (in_src_disk),
    .out_valid       (out_valid),
    .out_ready       (out_ready),
    .out_data        (out_data),
    .out_last        (out_last),
    .out_dst_disk    (out_dst_disk)
);

// File: tb/stripe_parity_unit_bench.sv
`timescale 1ns/1ps
module stripe_parity_unit_bench;
    localparam int N  = 5;
    localparam int W  = 32;
    localparam int B  = 4;
    localparam int LW = 16;
    localparam int DW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_op = '0;
    logic [LW-1:0] cmd_lba = '0;
    logic [DW-1:0] cmd_lost_disk = '0;
    logic [LW-1:0] cur_stripe;
    logic [DW-1:0] cur_data_disk;
    logic [DW-1:0] cur_parity_disk;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [W-1:0]  in_data = '0;
    logic [DW-1:0] in_src_disk;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [W-1:0]  out_data;
    logic          out_last;
    logic [DW-1:0] out_dst_disk;

    always #4 clk = ~clk;

    stripe_parity_unit #(.NUM_DISKS(N), .WORD_W(W), .BLK_WORDS(B), .LBA_W(LW)) u_stripe_parity_unit (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_lba(cmd_lba), .cmd_lost_disk(cmd_lost_disk),
        .cur_stripe(cur_stripe), .cur_data_disk(cur_data_disk), .cur_parity_disk(cur_parity_disk),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_src_disk(in_src_disk),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .out_dst_disk(out_dst_disk)
    );

    int vectors = 0;
    int misses  = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    endtask

    // per-clock handshake reference model (R7, R8, R10)
    int ph = 0;
    int mcnt = 0;
    int mtot = 0;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph <= 0; mcnt <= 0; mtot <= 0;
        end else if (ph == 0) begin
            if (cmd_valid && cmd_op != 2'd3) begin
                ph <= 1; mcnt <= 0;
                mtot <= ((cmd_op == 2'd1) ? 3 : N - 1) * B;
            end
        end else if (ph == 1) begin
            if (in_valid) begin
                if (mcnt + 1 == mtot) begin ph <= 2; mcnt <= 0; end
                else mcnt <= mcnt + 1;
            end
        end else begin
            if (out_ready) begin
                if (mcnt + 1 == B) begin ph <= 0; mcnt <= 0; end
                else mcnt <= mcnt + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R7 phase", {61'd0, cmd_ready, in_ready, out_valid},
                {61'd0, ph == 0, ph == 1, ph == 2});
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        misses++;
        $display("FAIL R7 watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    // shared stimulus and expectation storage
    logic [W-1:0] feed    [8][B];
    logic [W-1:0] exp_out [B];
    logic [W-1:0] img     [8][B];

    task automatic map_exp(input int lba, output int st, output int par, output int dat);
        int pos;
        st  = lba / (N - 1);
        pos = lba % (N - 1);
        par = (N - 1) - (st % N);
        dat = (pos < par) ? pos : pos + 1;
    endtask

    task automatic xor_feed(input int nblk);
        for (int w = 0; w < B; w++) begin
            exp_out[w] = '0;
            for (int b = 0; b < nblk; b++) exp_out[w] ^= feed[b][w];
        end
    endtask

    task automatic run_op(input int op, input int lba, input int lost, input bit stall, input bit bubble);
        int st, par, dat, nblk, dst;
        int srcs [8];
        int k;
        string tag;
        logic [W-1:0] held;
        map_exp(lba, st, par, dat);
        tag  = (op == 0) ? "R3" : (op == 1) ? "R5" : "R6";
        nblk = (op == 1) ? 3 : N - 1;
        dst  = (op == 2) ? lost : par;
        if (op == 1) begin
            srcs[0] = dat; srcs[1] = par; srcs[2] = dat;
        end else begin
            k = 0;
            for (int d = 0; d < N; d++) if (d != dst) begin srcs[k] = d; k++; end
        end
        @(negedge clk);
        chk("R10 idle before command", {63'd0, cmd_ready}, 64'd1);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_lba = LW'(lba); cmd_lost_disk = DW'(lost);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R1 stripe", 64'(cur_stripe), 64'(st));
        chk("R1 parity drive", 64'(cur_parity_disk), 64'(par));
        chk("R2 data drive", 64'(cur_data_disk), 64'(dat));
        for (int b = 0; b < nblk; b++) begin
            for (int w = 0; w < B; w++) begin
                if (bubble && w == 1) begin
                    in_valid = 1'b0;
                    @(posedge clk);
                    @(negedge clk);
                end
                in_valid = 1'b1;
                in_data  = feed[b][w];
                chk((op == 0) ? "R4 source drive" : (op == 1) ? "R5 source drive" : "R6 source drive",
                    64'(in_src_disk), 64'(srcs[b]));
                @(posedge clk);
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        for (int w = 0; w < B; w++) begin
            if (stall && w == 1) begin
                out_ready = 1'b0;
                held = out_data;
                @(posedge clk);
                @(negedge clk);
                chk("R7 stalled word held", 64'(out_data), 64'(held));
            end
            chk({tag, " result word"}, 64'(out_data), 64'(exp_out[w]));
            chk({tag, " destination drive"}, 64'(out_dst_disk), 64'(dst));
            chk("R10 last flag", {63'd0, out_last}, {63'd0, w == B - 1});
            out_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            out_ready = 1'b0;
        end
        chk("R10 idle after result", {63'd0, cmd_ready}, 64'd1);
    endtask

    initial begin
        int st, par, dat, lba;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 cmd_ready", {63'd0, cmd_ready}, 64'd1);
        chk("R9 in_ready", {63'd0, in_ready}, 64'd0);
        chk("R9 out_valid", {63'd0, out_valid}, 64'd0);
        chk("R9 cur_stripe", 64'(cur_stripe), 64'd0);
        chk("R9 cur drives", 64'({cur_data_disk, cur_parity_disk}), 64'd0);
        rst_n = 1'b1;

        // full-stripe writes: parity visits every drive position
        for (int s = 0; s < 6; s++) begin
            for (int b = 0; b < N - 1; b++)
                for (int w = 0; w < B; w++)
                    feed[b][w] = {8'(s), 8'(b), 8'(w), 8'h5A} ^ (32'h9E37_79B9 * (s + 1));
            xor_feed(N - 1);
            run_op(0, s * (N - 1) + (s % (N - 1)), 0, s[0], s == 3);
        end

        // build a known stripe (stripe 2) and record each drive's contents
        lba = 2 * (N - 1);
        map_exp(lba, st, par, dat);
        for (int b = 0; b < N - 1; b++)
            for (int w = 0; w < B; w++)
                feed[b][w] = 32'hC0DE_0000 + 32'(b * 16 + w) * 32'h0101_0101;
        xor_feed(N - 1);
        run_op(0, lba, 0, 1'b0, 1'b0);
        begin
            int k = 0;
            for (int d = 0; d < N; d++) begin
                for (int w = 0; w < B; w++) img[d][w] = (d == par) ? exp_out[w] : feed[k][w];
                if (d != par) k++;
            end
        end

        // small write to the second block of stripe 2
        map_exp(lba + 1, st, par, dat);
        for (int w = 0; w < B; w++) begin
            feed[0][w] = img[dat][w];
            feed[1][w] = img[par][w];
            feed[2][w] = 32'hFACE_0000 ^ 32'(w * 7 + 3);
        end
        for (int w = 0; w < B; w++) begin
            exp_out[w] = '0;
            for (int d = 0; d < N; d++)
                if (d != par) exp_out[w] ^= (d == dat) ? feed[2][w] : img[d][w];
        end
        run_op(1, lba + 1, 0, 1'b1, 1'b0);
        for (int w = 0; w < B; w++) begin
            img[dat][w] = feed[2][w];
            img[par][w] = exp_out[w];
        end

        // rebuild lost drives: lowest, highest, parity and data drive
        for (int t = 0; t < 4; t++) begin
            int lost, k;
            lost = (t == 0) ? 0 : (t == 1) ? N - 1 : (t == 2) ? par : dat;
            k = 0;
            for (int d = 0; d < N; d++)
                if (d != lost) begin
                    for (int w = 0; w < B; w++) feed[k][w] = img[d][w];
                    k++;
                end
            for (int w = 0; w < B; w++) exp_out[w] = img[lost][w];
            run_op(2, lba + t, lost, t[0], t == 2);
        end

        // second small write on another stripe, back to back
        map_exp(17, st, par, dat);
        for (int w = 0; w < B; w++) begin
            feed[0][w] = 32'h1111_0000 + 32'(w);
            feed[1][w] = 32'h2222_0000 + 32'(w);
            feed[2][w] = 32'h4444_0000 + 32'(w);
        end
        xor_feed(3);
        run_op(1, 17, 0, 1'b0, 1'b1);

        // opcode 3 does nothing
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd3; cmd_lba = LW'(33);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int c = 0; c < 3; c++) begin
            chk("R8 no input requested", {63'd0, in_ready}, 64'd0);
            chk("R8 no output", {63'd0, out_valid}, 64'd0);
            chk("R8 still idle", {63'd0, cmd_ready}, 64'd1);
            chk("R8 mapping untouched", 64'(cur_stripe), 64'(st));
            @(posedge clk);
            @(negedge clk);
        end

        summary();
        $finish;
    end
endmodule